// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is the local timer of one processor core. A tick prescaler divides the core clock by a programmable value plus one. Each tick it produces decrements an interrupt down-counter. When that counter expires, the block sets a status flag, and the flag drives the interrupt line if it is enabled. In interval mode the down-counter reloads from its buffer and keeps firing at a fixed period. In single-shot mode it fires once and then stays idle until software restarts it.

Software programs the block through a small register window on a simple write/read bus. A write takes effect at the clock edge on which `wr_en` is high. Reads are combinational from `addr`. The two count buffers, the control bits, the W1C status bit and the interrupt enable each sit at a fixed offset within the window. The interrupt count buffer accepts a new value only when the written word carries a load flag in its top bit. Starting the timer always makes both counters begin from their buffer values.

Top module: `core_tick_timer`

## Requirements
- R1: After reset, every register in the window reads 0 and `irq` is low.
- R2: The tick buffer at offset 0x00 is 32 bits wide and reads back what was written. While running, the prescaler emits one tick every T+1 clock cycles, where T is the buffer value, so T=1 halves the clock.
- R3: A write to offset 0x08 with bit 31 set loads bits 30:0 as the interrupt count N. A write to 0x08 with bit 31 clear is ignored. The register reads back as {1'b0, N}.
- R4: The control register at 0x20 holds three bits: bit 0 runs the tick prescaler, bit 1 runs the interrupt counter, and bit 2 selects interval (auto-reload) mode. Bits above 2 read as 0.
- R5: When control bits 0 and 1 are both set by a write, status bit 0 (offset 0x30) becomes 1 exactly N*(T+1) clock edges after that write edge. N=0 behaves as N=1.
- R6: In interval mode the status bit sets again every N*(T+1) edges, for as long as the timer runs.
- R7: In single-shot mode (bit 2 clear) the counter produces exactly one event and then stays at zero, with no further events.
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: Enable bit 0 at offset 0x34 gates the interrupt: `irq` equals status AND enable.
- R10: Clearing control bits 0 and 1 stops the timer, and no further events occur. A later start counts the full N*(T+1) from the restart edge, because both counters reload from their buffers.
- R11: Setting only one of control bits 0 or 1 produces no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Interrupt request (status AND enable) |

## Verification
The hardest case to reach is the exact edge on which a repeat event lands after a status clear. It depends on the prescaler divide, the interrupt count and the one-cycle delay of the clear write all lining up. The bench computes N*(T+1) for each trial. It samples the status bit one edge before and exactly at the expected event, and it does this for the first event and for the reload event. Random trials draw T, N, the mode and the enable bit from a fixed seed. Directed cases add a stop followed by a restart, a single-shot run watched long after its event, a W1C write of zero, and starts with only one of the two run bits set.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [7:0] OFS_TICK_BUF = 8'h00;
  localparam logic [7:0] OFS_ICNT_BUF = 8'h08;
  localparam logic [7:0] OFS_CONTROL  = 8'h20;
  localparam logic [7:0] OFS_STATUS   = 8'h30;
  localparam logic [7:0] OFS_ENABLE   = 8'h34;

  localparam int CTL_RUN_TICK = 0;
  localparam int CTL_RUN_INT  = 1;
  localparam int CTL_INTERVAL = 2;
  localparam int CTL_W        = 3;

  typedef struct packed {
    logic interval;
    logic run_int;
    logic run_tick;
  } ctl_t;
endpackage

// File: rtl/tt_rst_sync.sv
module tt_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = run_i && at_zero;

  always_comb begin
    if (!run_i || at_zero) begin
      cnt_d = buf_i;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  reload_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_o) |=> (cnt_q == $past(buf_i)));
endmodule

// File: rtl/tt_interval_counter.sv
module tt_interval_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             interval_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic             evt_o
);
  logic [CNT_W-1:0] icnt_q;
  logic [CNT_W-1:0] icnt_d;
  logic             spent_q;
  logic             spent_d;
  logic             expiring;

  assign expiring = (icnt_q <= CNT_W'(1));

  always_comb begin
    icnt_d  = icnt_q;
    spent_d = spent_q;
    evt_o   = 1'b0;
    if (!active_i) begin
      icnt_d  = buf_i;
      spent_d = 1'b0;
    end else if (tick_i && !spent_q) begin
      if (expiring) begin
        evt_o = 1'b1;
        if (interval_i) begin
          icnt_d = buf_i;
        end else begin
          icnt_d  = '0;
          spent_d = 1'b1;
        end
      end else begin
        icnt_d = icnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q  <= '0;
      spent_q <= 1'b0;
    end else begin
      icnt_q  <= icnt_d;
      spent_q <= spent_d;
    end
  end

  // R6
  interval_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && interval_i) |=> (icnt_q == $past(buf_i)));

  // R7
  oneshot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !interval_i) |=> !evt_o);
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ICNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] tick_buf_o,
  output logic [ICNT_W-1:0] icnt_buf_o,
  output ctl_t              ctl_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] tick_q, tick_d;
  logic [ICNT_W-1:0] ibuf_q, ibuf_d;
  ctl_t              ctl_q, ctl_d;
  logic              stat_q, stat_d;
  logic              en_q, en_d;
  logic              wr_tick, wr_ibuf, wr_ctl, wr_stat, wr_en_reg;

  assign wr_tick   = wr_en_i && (addr_i == OFS_TICK_BUF);
  assign wr_ibuf   = wr_en_i && (addr_i == OFS_ICNT_BUF) && wdata_i[DATA_W-1];
  assign wr_ctl    = wr_en_i && (addr_i == OFS_CONTROL);
  assign wr_stat   = wr_en_i && (addr_i == OFS_STATUS);
  assign wr_en_reg = wr_en_i && (addr_i == OFS_ENABLE);

  always_comb begin
    tick_d = wr_tick   ? wdata_i                 : tick_q;
    ibuf_d = wr_ibuf   ? wdata_i[ICNT_W-1:0]     : ibuf_q;
    ctl_d  = wr_ctl    ? ctl_t'(wdata_i[CTL_W-1:0]) : ctl_q;
    en_d   = wr_en_reg ? wdata_i[0]              : en_q;
    stat_d = stat_q;
    if (wr_stat && wdata_i[0]) begin
      stat_d = 1'b0;
    end
    if (evt_i) begin
      stat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      ibuf_q <= '0;
      ctl_q  <= '0;
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      tick_q <= tick_d;
      ibuf_q <= ibuf_d;
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_TICK_BUF: rdata_o = tick_q;
      OFS_ICNT_BUF: rdata_o = {1'b0, ibuf_q};
      OFS_CONTROL:  rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      OFS_STATUS:   rdata_o = {{(DATA_W-1){1'b0}}, stat_q};
      OFS_ENABLE:   rdata_o = {{(DATA_W-1){1'b0}}, en_q};
      default:      rdata_o = '0;
    endcase
  end

  assign tick_buf_o = tick_q;
  assign icnt_buf_o = ibuf_q;
  assign ctl_o      = ctl_q;
  assign irq_o      = stat_q && en_q;

  // R3
  ignore_unflagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (addr_i == OFS_ICNT_BUF) && !wdata_i[DATA_W-1]) |=> $stable(ibuf_q));

  // R5
  status_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(evt_i));
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ICNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              core_rst_n;
  logic [DATA_W-1:0] tick_buf;
  logic [ICNT_W-1:0] icnt_buf;
  ctl_t              ctl;
  logic              tick;
  logic              evt;

  tt_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );

  tt_regs #(.DATA_W(DATA_W)) i_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .evt_i      (evt),
    .rdata_o    (rdata),
    .tick_buf_o (tick_buf),
    .icnt_buf_o (icnt_buf),
    .ctl_o      (ctl),
    .irq_o      (irq)
  );

  tt_prescaler #(.CNT_W(DATA_W)) i_prescaler (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .run_i  (ctl.run_tick),
    .buf_i  (tick_buf),
    .tick_o (tick)
  );

  tt_interval_counter #(.CNT_W(ICNT_W)) i_icnt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .active_i   (ctl.run_tick && ctl.run_int),
    .tick_i     (tick),
    .interval_i (ctl.interval),
    .buf_i      (icnt_buf),
    .evt_o      (evt)
  );

  // R11
  no_event_half_started_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(ctl.run_tick && ctl.run_int) |-> !evt);
endmodule

// File: tb/test_core_tick_timer.sv
`timescale 1ns/1ps
module test_core_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  core_tick_timer i_core_tick_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq   (irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int period(input int t, input int n);
    return ((n == 0) ? 1 : n) * (t + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_trial(input int t, input int n, input bit intv, input bit en);
    logic [31:0] v;
    int m;
    m = period(t, n);
    wr(8'h00, t);
    wr(8'h08, 32'h8000_0000 | n);
    wr(8'h34, {31'd0, en});
    wr(8'h20, {29'd0, intv, 2'b11});
    wait_n(m - 1);
    rd(8'h30, v); check("R5 status before first event", v, 0);
    wait_n(1);
    rd(8'h30, v); check("R5 status at first event", v, 1);
    check("R9 irq equals status and enable", {31'd0, irq}, {31'd0, en});
    wr(8'h30, 32'h1);
    rd(8'h30, v); check("R8 status cleared by writing 1", v, 0);
    if (intv) begin
      wait_n(m - 2);
      rd(8'h30, v); check("R6 status before repeat event", v, 0);
      wait_n(1);
      rd(8'h30, v); check("R6 status at repeat event", v, 1);
      wr(8'h20, 32'h0);
      wr(8'h30, 32'h1);
      wait_n(3 * m);
      rd(8'h30, v); check("R10 no event after stop", v, 0);
    end else begin
      wait_n(3 * m);
      rd(8'h30, v); check("R7 single-shot does not repeat", v, 0);
      wr(8'h20, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] v;
    int t, n;
    bit intv, en;
    rst_n = 1'b0;
    wr_en = 1'b0;
    addr  = 8'h00;
    wdata = 32'h0;
    void'($urandom(32'h00C0FFEE));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    rd(8'h00, v); check("R1 tick buffer reset", v, 0);
    rd(8'h08, v); check("R1 count buffer reset", v, 0);
    rd(8'h20, v); check("R1 control reset", v, 0);
    rd(8'h30, v); check("R1 status reset", v, 0);
    rd(8'h34, v); check("R1 enable reset", v, 0);
    check("R1 irq low after reset", {31'd0, irq}, 0);

    wr(8'h00, 32'h0000_A5A5);
    rd(8'h00, v); check("R2 tick buffer readback", v, 32'h0000_A5A5);
    wr(8'h08, 32'h8000_0005);
    rd(8'h08, v); check("R3 flagged load", v, 5);
    wr(8'h08, 32'h0000_0009);
    rd(8'h08, v); check("R3 unflagged write ignored", v, 5);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R3 31-bit count readback", v, 32'h7FFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R4 control holds three bits", v, 7);
    wr(8'h20, 32'h0);

    // R2 halving: T=1, N=3 single-shot, enable on
    run_trial(1, 3, 1'b0, 1'b1);
    // R6 interval with T=0
    run_trial(0, 4, 1'b1, 1'b1);
    // R5 N=0 behaves as N=1 (T=2 gives period 3)
    run_trial(2, 0, 1'b0, 1'b0);

    // R3 ignored write must not change timing: load 2, then unflagged 7
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h8000_0002);
    wr(8'h08, 32'h0000_0007);
    wr(8'h20, 32'h3);
    wait_n(3);
    rd(8'h30, v); check("R3 timing uses flagged count (before)", v, 0);
    wait_n(1);
    rd(8'h30, v); check("R3 timing uses flagged count (at)", v, 1);
    // R8 writing 0 to status leaves it set
    wr(8'h30, 32'h0);
    rd(8'h30, v); check("R8 writing 0 keeps status", v, 1);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);

    // R10 stop mid-count then restart counts from buffers
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h8000_0002);
    wr(8'h20, 32'h3);
    wait_n(3);
    wr(8'h20, 32'h0);
    wr(8'h20, 32'h3);
    wait_n(5);
    rd(8'h30, v); check("R10 restart from buffers (before)", v, 0);
    wait_n(1);
    rd(8'h30, v); check("R10 restart from buffers (at)", v, 1);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);

    // R11 only one run bit set
    wr(8'h00, 32'd0);
    wr(8'h08, 32'h8000_0001);
    wr(8'h20, 32'h5);
    wait_n(20);
    rd(8'h30, v); check("R11 tick run only gives no event", v, 0);
    wr(8'h20, 32'h6);
    wait_n(20);
    rd(8'h30, v); check("R11 int run only gives no event", v, 0);
    wr(8'h20, 32'h0);

    // R9 status set with enable off keeps irq low
    wr(8'h34, 32'h0);
    wr(8'h20, 32'h3);
    wait_n(2);
    rd(8'h30, v); check("R9 status set", v, 1);
    check("R9 irq gated off", {31'd0, irq}, 0);
    wr(8'h34, 32'h1);
    check("R9 irq follows enable", {31'd0, irq}, 1);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h0);

    for (int k = 0; k < 10; k++) begin
      t    = int'($urandom % 4);
      n    = 2 + int'($urandom % 5);
      intv = 1'($urandom % 2);
      en   = 1'($urandom % 2);
      run_trial(t, n, intv, en);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule